// File: doc/BRIEF.md
# Two-Processor Doorbell Interrupt Unit

A memory-mapped doorbell that two processors use to signal one another. Each processor owns a 4-bit flag word. Any bus agent can raise flags through a write-one-to-set register and drop them through a write-one-to-clear register. The current flags can be read back from a status register. Each flag word drives one level-sensitive interrupt line. That line stays high for as long as at least one of the word's flags is set.

The block holds no message payload and performs no security or privilege checks. Any protocol built on top of the doorbell is defined by software. Register accesses are single-cycle 32-bit transfers within a 4 KB window. The read data and an error pulse appear one cycle after the request. The error pulse flags any access that hits nothing, is misaligned, or goes in the wrong direction for its register. A fixed block of identification bytes sits at the top of the window.

Top module: `doorbell_mbox`

## Requirements
- R1: Channel c (c = 0 or 1) places its status register at byte offset c*0x10, its set register at c*0x10+0x4 and its clear register at c*0x10+0x8.
- R2: Only data bits [3:0] of a write act on a flag word. Bits [31:4] are ignored, and a status read returns zero in bits [31:4].
- R3: A write to a set register ORs data bits [3:0] into that channel's flags from the next cycle on, and leaves the other channel's flags unchanged.
- R4: A write to a clear register drops every flag whose data bit is 1 and keeps the rest, from the next cycle on.
- R5: irq_o[c] is 1 exactly when channel c's flag word is nonzero. It follows each write from the cycle after the write.
- R6: A read of a set or clear register returns 0. A write to a status register or an identification register leaves both flag words unchanged.
- R7: Reads of the words at 0xFD0 through 0xFFC return, in rising address order, the bytes 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended to 32 bits.
- R8: While rst_ni is low, both flag words and both interrupts are 0, and so are rdata_o and err_o.
- R9: A read of any offset that maps to no register returns 0. A write to such an offset changes no flag. An address with bits [1:0] nonzero counts as mapping to no register.
- R10: err_o is 1 for exactly the one cycle after an access to an unmapped or misaligned offset, a read of a set or clear register, or a write to a status or identification register. It is 0 otherwise.
- R11: rdata_o carries the result of a read in the cycle after the request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one transfer per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| irq_o | output | 2 | Level interrupt per channel |
| err_o | output | 1 | One-cycle pulse on a bad access |

## Verification
The embedded properties check four things on every cycle. A set never loses a flag and always adds the written ones. A clear always removes the written ones. Flags hold when neither strobe is active, and at most one strobe fires per cycle. Bad accesses and write-only reads are reported the cycle after they occur. Other behaviour can only be shown by the bench's sweeps: that the right offsets reach the right channel, the exact OR and AND-NOT results over all pairs of 4-bit values, the ID byte contents, and that the interrupt level matches the flag word. The sweeps also cover the window-wide reads and writes that show unmapped offsets are inert.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_STAT,
    K_SET,
    K_CLR,
    K_ID,
    K_BAD
  } acc_kind_e;

  localparam int unsigned ID_COUNT = 12;

  // identification bytes, indexed in rising address order
  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h56;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h0B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/dbmb_decode.sv
module dbmb_decode
  import dbmb_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned AW     = 12,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  output acc_kind_e       kind_o,
  output logic [CH_W-1:0] ch_o,
  output logic [3:0]      id_idx_o,
  output logic            bad_o
);

  localparam int unsigned WW = AW - 2;
  localparam logic [WW-1:0] ID_FIRST = WW'((1 << WW) - ID_COUNT);

  logic [WW-1:0] word;
  logic [AW-5:0] ch_field;
  logic [1:0]    reg_field;

  assign word      = addr_i[AW-1:2];
  assign ch_field  = word[WW-1:2];
  assign reg_field = word[1:0];
  assign ch_o      = ch_field[CH_W-1:0];
  assign id_idx_o  = word[3:0] - ID_FIRST[3:0];

  always_comb begin
    kind_o = K_NONE;
    if (req_i) begin
      kind_o = K_BAD;
      if (addr_i[1:0] == 2'b00) begin
        if ({1'b0, ch_field} < (AW-3)'(NUM_CH)) begin
          case (reg_field)
            2'd0:    kind_o = K_STAT;
            2'd1:    kind_o = K_SET;
            2'd2:    kind_o = K_CLR;
            default: kind_o = K_BAD;
          endcase
        end else if (word >= ID_FIRST) begin
          kind_o = K_ID;
        end
      end
    end
  end

  // wrong direction counts as a bad access
  always_comb begin
    case (kind_o)
      K_BAD:          bad_o = 1'b1;
      K_STAT, K_ID:   bad_o = we_i;
      K_SET, K_CLR:   bad_o = ~we_i;
      default:        bad_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbmb_chan.sv
module dbmb_chan #(
  parameter int unsigned FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [FLAG_W-1:0] bits_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);

  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (set_i) flags_q <= flags_q | bits_i;
    else if (clr_i) flags_q <= flags_q & ~bits_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;

  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R3
  AST_SET_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((flags_q & $past(bits_i)) == $past(bits_i))); // R3
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((flags_q & $past(bits_i)) == '0)); // R4
  AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((flags_q & ~$past(bits_i)) == ($past(flags_q) & ~$past(bits_i)))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flags_q)); // R6

endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import dbmb_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned FLAG_W = 4,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              err_o
);

  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  acc_kind_e         kind;
  logic [CH_W-1:0]   ch_sel;
  logic [3:0]        id_idx;
  logic              bad;
  logic [FLAG_W-1:0] flags [NUM_CH];
  logic [NUM_CH-1:0] set_we, clr_we;
  logic [DW-1:0]     rdata_d, rdata_q;
  logic              err_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[DW-1:FLAG_W];

  dbmb_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .kind_o  (kind),
    .ch_o    (ch_sel),
    .id_idx_o(id_idx),
    .bad_o   (bad)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign set_we[c] = we_i && (kind == K_SET) && (ch_sel == CH_W'(c));
    assign clr_we[c] = we_i && (kind == K_CLR) && (ch_sel == CH_W'(c));

    dbmb_chan #(.FLAG_W(FLAG_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_we[c]),
      .clr_i  (clr_we[c]),
      .bits_i (wdata_i[FLAG_W-1:0]),
      .flags_o(flags[c]),
      .irq_o  (irq_o[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (!we_i) begin
      case (kind)
        K_STAT:  rdata_d = DW'(flags[ch_sel]);
        K_ID:    rdata_d = DW'(id_byte(id_idx));
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= bad;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  AST_BAD_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bad) |=> err_o); // R10
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i)); // R10
  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (kind == K_SET || kind == K_CLR)) |=> (rdata_o == '0)); // R6
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (rdata_o == '0)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_we, clr_we})); // R3

endmodule

// File: tb/sim_doorbell_mbox.sv
`timescale 1ns/1ps
module sim_doorbell_mbox;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  logic        err;

  int n_vec = 0;
  int n_bad = 0;
  logic [3:0]  m [2];
  logic [31:0] got_rd;
  logic        got_err;

  always #2.5 clk = ~clk;

  doorbell_mbox u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    got_rd  = rdata;
    got_err = err;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                           8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  task automatic chk_state(input string tag);
    acc(1'b0, 12'h000, 32'h0);
    chk({tag, " R1 stat0"}, got_rd, {28'h0, m[0]});
    acc(1'b0, 12'h010, 32'h0);
    chk({tag, " R1 stat1"}, got_rd, {28'h0, m[1]});
    chk({tag, " R5 irq"}, {30'h0, irq}, {30'h0, (m[1] != 0), (m[0] != 0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m[0] = '0; m[1] = '0;
    #1;
    // R8 values during reset
    chk("R8 irq in reset", {30'h0, irq}, 32'h0);
    chk("R8 rdata in reset", rdata, 32'h0);
    chk("R8 err in reset", {31'h0, err}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk_state("R8 after reset");

    // R3 R2 R5: OR sweep over every pair, both channels
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [11:0] base;
          base = 12'(c * 16);
          acc(1'b1, base + 12'h8, 32'hFFFF_FFFF);
          acc(1'b1, base + 12'h4, 32'hA5A5_A5A0 | 32'(a));
          acc(1'b1, base + 12'h4, 32'h5A5A_5A50 | 32'(b));
          chk("R10 good write no err", {31'h0, got_err}, 32'h0);
          chk("R5 irq level", {31'h0, irq[c]}, {31'h0, ((a | b) != 0)});
          acc(1'b0, base, 32'h0);
          chk("R3 R2 set result", got_rd, 32'(a | b));
          m[c] = 4'(a | b);
          chk("R3 other chan", {31'h0, irq[1-c]}, {31'h0, (m[1-c] != 0)});
          @(posedge clk); #1;
          chk("R11 rdata idle", rdata, 32'h0);
        end
      end
    end

    // R4 R2: AND-NOT sweep
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [11:0] base;
          base = 12'(c * 16);
          acc(1'b1, base + 12'h8, 32'hFFFF_FFFF);
          acc(1'b1, base + 12'h4, 32'(a));
          acc(1'b1, base + 12'h8, 32'hFFFF_FFF0 & ~32'hF | 32'(b));
          chk("R5 irq after clear", {31'h0, irq[c]}, {31'h0, ((a & ~b & 15) != 0)});
          acc(1'b0, base, 32'h0);
          chk("R4 clear result", got_rd, 32'(a & ~b & 15));
          m[c] = 4'(a & ~b & 15);
        end
      end
    end

    // window read sweep: R1 R6 R7 R9 R10
    acc(1'b1, 12'h008, 32'hF); acc(1'b1, 12'h004, 32'h5); m[0] = 4'h5;
    acc(1'b1, 12'h018, 32'hF); acc(1'b1, 12'h014, 32'hA); m[1] = 4'hA;
    for (int w = 0; w < 1024; w++) begin
      logic [31:0] ed;
      logic        ee;
      int ch, r;
      ch = w / 4; r = w % 4;
      if (ch < 2) begin
        ed = (r == 0) ? {28'h0, m[ch]} : 32'h0;
        ee = (r != 0);
      end else if (w >= 1012) begin
        ed = {24'h0, exp_id(w - 1012)};
        ee = 1'b0;
      end else begin
        ed = 32'h0;
        ee = 1'b1;
      end
      acc(1'b0, 12'(w * 4), 32'h0);
      chk("R7 R9 R6 read data", got_rd, ed);
      chk("R10 read err", {31'h0, got_err}, {31'h0, ee});
      @(posedge clk); #1;
      chk("R10 err one cycle", {31'h0, err}, 32'h0);
    end

    // window write sweep to everything but set/clear: R6 R9 R10
    for (int w = 0; w < 1024; w++) begin
      if (!((w / 4) < 2 && ((w % 4) == 1 || (w % 4) == 2))) begin
        acc(1'b1, 12'(w * 4), (w % 2 == 0) ? 32'hFFFF_FFFF : 32'h0);
        chk("R10 write err", {31'h0, got_err}, 32'h1);
        chk("R6 R9 irq kept", {30'h0, irq}, 32'h3);
      end
    end
    chk_state("R6 R9 flags kept");

    // misaligned: R9 R10
    acc(1'b1, 12'h005, 32'hF);
    chk("R10 misaligned write err", {31'h0, got_err}, 32'h1);
    acc(1'b1, 12'h00A, 32'hF);
    chk("R10 misaligned write err", {31'h0, got_err}, 32'h1);
    acc(1'b0, 12'h001, 32'h0);
    chk("R9 misaligned read", got_rd, 32'h0);
    chk("R10 misaligned read err", {31'h0, got_err}, 32'h1);
    acc(1'b0, 12'hFD2, 32'h0);
    chk("R9 misaligned id read", got_rd, 32'h0);
    chk_state("R9 misaligned no effect");

    // reset mid-run: R8
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R8 irq cleared", {30'h0, irq}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    m[0] = '0; m[1] = '0;
    chk_state("R8 flags cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule